// File: doc/BRIEF.md
# Four-Bank DRAM Command Sequencer

This block turns a stream of single read or write requests into the command sequence that a four-bank synchronous DRAM expects. Each request carries a bank, a row and a column, together with a flag that asks for the row to close by itself once the burst ends. The sequencer keeps a record of which row is open in each bank. A request that hits the open row goes straight to the column command. A request to a closed bank first opens the row. A request to a bank where another row is open first closes that row and then opens the new one. Per-bank timers enforce row-to-column, precharge, active-to-precharge and write-recovery spacing. A column-to-column counter keeps bursts from being cut short.

A refresh timer, sized from a clock-frequency parameter, raises a refresh request early enough that the gap between two refresh commands never exceeds the 15.6 us bound. A pending refresh wins over new requests. It closes every open bank with a single precharge-all and then issues the refresh. Commands leave the block registered on the rising clock edge, and every cycle without a command carries a NOP. A strobe output marks the clock cycles in which read data is due at the fixed CAS latency of three.

Top module: `sdram_cmd_seq`

## Requirements
- R1: The command lines {cs_n, ras_n, cas_n, we_n} carry only these codes: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, REFRESH 0001. While reset is held and on every idle cycle the block drives NOP with bank and address zero.
- R2: A request to a bank with no open row issues ACTIVE with the bank on `cmd_ba` and the row on `cmd_addr[ROW_W-1:0]`.
- R3: The READ or WRITE command follows that ACTIVE exactly T_RCD cycles later, when nothing else delays it. It carries the column on `cmd_addr[COL_W-1:0]` and the auto-precharge flag on `cmd_addr[AP_BIT]`. `req_ready` is high in the cycle before the clock edge that issues the command, and only then.
- R4: A request that hits the open row of its bank issues no ACTIVE. Successive column commands are at least BURST_LEN/2 cycles apart.
- R5: A request that misses the open row issues PRECHARGE to that bank with `cmd_addr[AP_BIT]`=0. That PRECHARGE comes no sooner than T_RAS cycles after the bank's ACTIVE. It is followed T_RP cycles later by ACTIVE of the new row and then T_RCD cycles later by the access.
- R6: After an access with auto-precharge, the bank counts as closed. The next access to that bank, even to the same row, issues ACTIVE without PRECHARGE. That ACTIVE comes no sooner than BURST_LEN/2 (+T_WR for a write) + T_RP cycles after the access.
- R7: Before REFRESH, any open banks are closed by one PRECHARGE with `cmd_addr[AP_BIT]`=1, issued T_RP cycles before the REFRESH. No ACTIVE follows a REFRESH within T_RFC cycles.
- R8: Consecutive REFRESH commands are at most CLK_MHZ*REFI_NS/1000 cycles apart, even under a continuous stream of requests.
- R9: `rd_capture` is high for BURST_LEN/2 cycles. It starts CAS latency (3) cycles after the cycle in which READ appears on the command lines, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands change on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; held with its fields until accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_autopre | input | 1 | Close the row automatically after this burst |
| req_bank | input | 2 | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Starting column |
| req_ready | output | 1 | Request accepted at the coming edge |
| rd_capture | output | 1 | Read data expected on the bus this cycle |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | 2 | Bank address |
| cmd_addr | output | ADDR_W | Row, column or precharge-mode address |

## Verification
The bench targets the three row cases: a closed bank, a hit and a miss. A sequencer that lost track of open rows would send a needless ACTIVE on a hit, or would open a second row without closing the first. It checks that an auto-precharged bank is reopened without a PRECHARGE and only after burst, write-recovery and precharge time, since a wrong tracker would issue PRECHARGE or reopen the bank too early. A refresh with a bank open must use precharge-all and then the T_RP gap, and a stream of back-to-back requests must not push refresh spacing past its bound. The bench also times the read-data strobe cycle by cycle, where an off-by-one latency would show at once.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_WR  = 4'b0100,
    CMD_PRE = 4'b0010,
    CMD_REF = 4'b0001
  } cmd_e;

  localparam int unsigned CAS_LATENCY = 3;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // cycles between refreshes for a clock of mhz and an interval of ns
  function automatic int unsigned refi_cycles(input int unsigned mhz, input int unsigned ns);
    return (mhz * ns) / 1000;
  endfunction

  // cycles a bank stays busy after a column command before it may close
  function automatic int unsigned hold_cycles(input int unsigned bl, input int unsigned twr,
                                              input bit wr);
    return bl / 2 + (wr ? twr : 0);
  endfunction

endpackage

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
  parameter int unsigned REFI_CYC = 1560,
  parameter int unsigned SLACK    = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_issue,
  output logic ref_pend
);
  localparam int unsigned CW = $clog2(REFI_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= CW'(REFI_CYC - 1);
    else if (ref_issue)      cnt <= CW'(REFI_CYC - 1);
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  // raise the request early so service latency stays inside the interval
  assign ref_pend = (cnt <= CW'(SLACK));

endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
  import sdram_seq_pkg::*;
#(
  parameter int unsigned NB        = 4,
  parameter int unsigned BA_W      = 2,
  parameter int unsigned ROW_W     = 11,
  parameter int unsigned TMR_W     = 5,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_RAS     = 6,
  parameter int unsigned BURST_LEN = 4,
  parameter int unsigned T_WR      = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      act_en,
  input  logic                      pre_en,
  input  logic                      preall_en,
  input  logic                      acc_en,
  input  logic                      acc_wr,
  input  logic                      acc_ap,
  input  logic [BA_W-1:0]           sel_bank,
  input  logic [ROW_W-1:0]          sel_row,
  output logic [NB-1:0]             bank_open,
  output logic [NB-1:0][ROW_W-1:0]  bank_row,
  output logic [NB-1:0]             bank_free
);
  localparam int unsigned HOLD_RD = hold_cycles(BURST_LEN, T_WR, 1'b0);
  localparam int unsigned HOLD_WR = hold_cycles(BURST_LEN, T_WR, 1'b1);

  for (genvar gb = 0; gb < NB; gb++) begin : g_bank
    logic [TMR_W-1:0] tmr;
    logic [TMR_W-1:0] hold_v;
    logic [TMR_W-1:0] keep_v;
    logic [TMR_W-1:0] ap_v;
    logic             sel;

    assign sel = (sel_bank == BA_W'(gb));

    always_comb begin
      hold_v = acc_wr ? TMR_W'(HOLD_WR) : TMR_W'(HOLD_RD);
      keep_v = (tmr > hold_v - 1'b1) ? tmr : hold_v - 1'b1;
      ap_v   = ((tmr > hold_v) ? tmr : hold_v) + TMR_W'(T_RP - 1);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bank_open[gb] <= 1'b0;
        bank_row[gb]  <= '0;
        tmr           <= '0;
      end else if (preall_en) begin
        bank_open[gb] <= 1'b0;
        tmr           <= TMR_W'(T_RP - 1);
      end else if (sel && act_en) begin
        bank_open[gb] <= 1'b1;
        bank_row[gb]  <= sel_row;
        tmr           <= TMR_W'(T_RAS - 1);
      end else if (sel && pre_en) begin
        bank_open[gb] <= 1'b0;
        tmr           <= TMR_W'(T_RP - 1);
      end else if (sel && acc_en) begin
        if (acc_ap) begin
          bank_open[gb] <= 1'b0;
          tmr           <= ap_v;
        end else begin
          tmr           <= keep_v;
        end
      end else if (tmr != '0) begin
        tmr <= tmr - 1'b1;
      end
    end

    assign bank_free[gb] = (tmr == '0);
  end

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int unsigned CLK_MHZ   = 100,
  parameter int unsigned REFI_NS   = 15600,
  parameter int unsigned REF_SLACK = 64,
  parameter int unsigned ROW_W     = 11,
  parameter int unsigned COL_W     = 8,
  parameter int unsigned ADDR_W    = 11,
  parameter int unsigned AP_BIT    = 10,
  parameter int unsigned BURST_LEN = 4,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_RCD     = 3,
  parameter int unsigned T_RAS     = 6,
  parameter int unsigned T_WR      = 2,
  parameter int unsigned T_RFC     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_autopre,
  input  logic [1:0]        req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              req_ready,
  output logic              rd_capture,
  output logic              cmd_cs_n,
  output logic              cmd_ras_n,
  output logic              cmd_cas_n,
  output logic              cmd_we_n,
  output logic [1:0]        cmd_ba,
  output logic [ADDR_W-1:0] cmd_addr
);
  localparam int unsigned NBANK    = 4;
  localparam int unsigned BA_W     = 2;
  localparam int unsigned CAS_LAT  = CAS_LATENCY;
  localparam int unsigned BEATS    = BURST_LEN / 2;
  localparam int unsigned REFI_CYC = refi_cycles(CLK_MHZ, REFI_NS);
  localparam int unsigned WAIT_W   = $clog2(umax(umax(T_RP, T_RCD), T_RFC) + 1);
  localparam int unsigned CCD_W    = $clog2(BEATS + 1);
  localparam int unsigned TMR_W    = $clog2(T_RAS + hold_cycles(BURST_LEN, T_WR, 1'b1) + T_RP + 1);
  localparam int unsigned SR_LEN   = CAS_LAT + BEATS;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE_WAIT, ST_ACT_WAIT, ST_PALL_WAIT, ST_RFC_WAIT
  } st_e;

  st_e st, st_n;

  // named events that drive the command path and the checker
  logic act_issue, pre_issue, preall_issue, acc_issue, ref_issue;
  logic ref_pend;
  logic [NBANK-1:0]            bank_open;
  logic [NBANK-1:0][ROW_W-1:0] bank_row;
  logic [NBANK-1:0]            bank_free;
  logic all_free, req_hit;

  logic              ld_wait;
  logic [WAIT_W-1:0] wait_val, wait_cnt;
  logic [CCD_W-1:0]  ccd_cnt;
  logic [SR_LEN-1:0] rd_sr;

  cmd_e              cmd_sel, cmd_q;
  logic [BA_W-1:0]   ba_sel;
  logic [ADDR_W-1:0] addr_sel;

  sdram_ref_timer #(.REFI_CYC(REFI_CYC), .SLACK(REF_SLACK)) u_ref (
    .clk(clk), .rst_n(rst_n), .ref_issue(ref_issue), .ref_pend(ref_pend)
  );

  sdram_bank_track #(
    .NB(NBANK), .BA_W(BA_W), .ROW_W(ROW_W), .TMR_W(TMR_W),
    .T_RP(T_RP), .T_RAS(T_RAS), .BURST_LEN(BURST_LEN), .T_WR(T_WR)
  ) u_banks (
    .clk(clk), .rst_n(rst_n),
    .act_en(act_issue), .pre_en(pre_issue), .preall_en(preall_issue),
    .acc_en(acc_issue), .acc_wr(req_write), .acc_ap(req_autopre),
    .sel_bank(req_bank), .sel_row(req_row),
    .bank_open(bank_open), .bank_row(bank_row), .bank_free(bank_free)
  );

  assign all_free = &bank_free;
  assign req_hit  = bank_open[req_bank] && (bank_row[req_bank] == req_row);

  always_comb begin
    st_n         = st;
    act_issue    = 1'b0;
    pre_issue    = 1'b0;
    preall_issue = 1'b0;
    acc_issue    = 1'b0;
    ref_issue    = 1'b0;
    ld_wait      = 1'b0;
    wait_val     = '0;
    case (st)
      ST_IDLE: begin
        if (ref_pend) begin
          if (all_free) begin
            if (|bank_open) begin
              preall_issue = 1'b1;
              ld_wait      = 1'b1;
              wait_val     = WAIT_W'(T_RP - 1);
              st_n         = ST_PALL_WAIT;
            end else begin
              ref_issue = 1'b1;
              ld_wait   = 1'b1;
              wait_val  = WAIT_W'(T_RFC - 1);
              st_n      = ST_RFC_WAIT;
            end
          end
        end else if (req_valid) begin
          if (req_hit) begin
            acc_issue = (ccd_cnt == '0);
          end else if (bank_free[req_bank]) begin
            ld_wait = 1'b1;
            if (bank_open[req_bank]) begin
              pre_issue = 1'b1;
              wait_val  = WAIT_W'(T_RP - 1);
              st_n      = ST_PRE_WAIT;
            end else begin
              act_issue = 1'b1;
              wait_val  = WAIT_W'(T_RCD - 1);
              st_n      = ST_ACT_WAIT;
            end
          end
        end
      end
      ST_PRE_WAIT: if (wait_cnt == '0) begin
        act_issue = 1'b1;
        ld_wait   = 1'b1;
        wait_val  = WAIT_W'(T_RCD - 1);
        st_n      = ST_ACT_WAIT;
      end
      ST_ACT_WAIT: if (wait_cnt == '0 && ccd_cnt == '0) begin
        acc_issue = 1'b1;
        st_n      = ST_IDLE;
      end
      ST_PALL_WAIT: if (wait_cnt == '0) begin
        ref_issue = 1'b1;
        ld_wait   = 1'b1;
        wait_val  = WAIT_W'(T_RFC - 1);
        st_n      = ST_RFC_WAIT;
      end
      ST_RFC_WAIT: if (wait_cnt == '0) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  // command word and address for whichever event fires this cycle
  always_comb begin
    cmd_sel  = CMD_NOP;
    ba_sel   = '0;
    addr_sel = '0;
    if (act_issue) begin
      cmd_sel              = CMD_ACT;
      ba_sel               = req_bank;
      addr_sel[ROW_W-1:0]  = req_row;
    end else if (pre_issue) begin
      cmd_sel              = CMD_PRE;
      ba_sel               = req_bank;
    end else if (preall_issue) begin
      cmd_sel              = CMD_PRE;
      addr_sel[AP_BIT]     = 1'b1;
    end else if (ref_issue) begin
      cmd_sel              = CMD_REF;
    end else if (acc_issue) begin
      cmd_sel              = req_write ? CMD_WR : CMD_RD;
      ba_sel               = req_bank;
      addr_sel[COL_W-1:0]  = req_col;
      addr_sel[AP_BIT]     = req_autopre;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      wait_cnt <= '0;
      ccd_cnt  <= '0;
      rd_sr    <= '0;
      cmd_q    <= CMD_NOP;
      cmd_ba   <= '0;
      cmd_addr <= '0;
    end else begin
      st <= st_n;
      if (ld_wait)              wait_cnt <= wait_val;
      else if (wait_cnt != '0)  wait_cnt <= wait_cnt - 1'b1;
      if (acc_issue)            ccd_cnt  <= CCD_W'(BEATS - 1);
      else if (ccd_cnt != '0)   ccd_cnt  <= ccd_cnt - 1'b1;
      rd_sr    <= {rd_sr[SR_LEN-2:0], acc_issue & ~req_write};
      cmd_q    <= cmd_sel;
      cmd_ba   <= ba_sel;
      cmd_addr <= addr_sel;
    end
  end

  assign req_ready  = acc_issue;
  assign rd_capture = |rd_sr[SR_LEN-1:CAS_LAT];
  assign {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} = cmd_q;

endmodule

// File: rtl/sdram_cmd_seq_chk.sv
module sdram_cmd_seq_chk
  import sdram_seq_pkg::*;
#(
  parameter int unsigned CLK_MHZ = 100,
  parameter int unsigned REFI_NS = 15600
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_cs_n,
  input logic       cmd_ras_n,
  input logic       cmd_cas_n,
  input logic       cmd_we_n,
  input logic       req_ready,
  input logic [3:0] bank_open,
  input logic       act_issue,
  input logic       acc_issue,
  input logic       ref_issue
);
  localparam int unsigned LIMIT = refi_cycles(CLK_MHZ, REFI_NS);

  logic [3:0] code;
  int unsigned since_ref;

  assign code = {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};

  always_ff @(posedge clk) begin
    if (!rst_n)         since_ref <= 0;
    else if (ref_issue) since_ref <= 0;
    else                since_ref <= since_ref + 1;
  end

  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    code inside {CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF}); // R1

  AST_READY_THEN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> (code == CMD_RD || code == CMD_WR)); // R3

  AST_NO_ACCESS_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    act_issue |=> !acc_issue); // R3

  AST_REF_BANKS_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    ref_issue |-> (bank_open == 4'b0000)); // R7

  AST_REF_QUIET_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    ref_issue |=> !(act_issue || acc_issue || ref_issue)); // R7

  AST_REFI_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    since_ref <= LIMIT); // R8

endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(.CLK_MHZ(CLK_MHZ), .REFI_NS(REFI_NS)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n),
  .req_ready(req_ready), .bank_open(bank_open),
  .act_issue(act_issue), .acc_issue(acc_issue), .ref_issue(ref_issue)
);

// File: tb/sdram_cmd_seq_tb.sv
module sdram_cmd_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_MHZ = 20;
  localparam int REFI_NS = 15600;
  localparam int REFI    = CLK_MHZ * REFI_NS / 1000;
  localparam int SLACK   = 24;
  localparam int ROW_W = 11, COL_W = 8, ADDR_W = 11, AP = 10;
  localparam int BL = 4, BEATS = BL / 2, CL = 3;
  localparam int TRP = 3, TRCD = 3, TRAS = 6, TWR = 2, TRFC = 8;
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001;
  localparam int LOGN = 4096;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_autopre = 1'b0;
  logic [1:0] req_bank = '0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic req_ready, rd_capture, cs_n, ras_n, cas_n, we_n;
  logic [1:0] ba;
  logic [ADDR_W-1:0] addr;

  int total = 0, bad = 0;
  int cyc = 0;
  int lg_n = 0, ref_seen = 0, last_ref = 0;
  int lg_cyc [LOGN];
  logic [3:0] lg_cmd [LOGN];
  logic [1:0] lg_ba [LOGN];
  logic [ADDR_W-1:0] lg_addr [LOGN];

  sdram_cmd_seq #(
    .CLK_MHZ(CLK_MHZ), .REFI_NS(REFI_NS), .REF_SLACK(SLACK), .ROW_W(ROW_W), .COL_W(COL_W),
    .ADDR_W(ADDR_W), .AP_BIT(AP), .BURST_LEN(BL), .T_RP(TRP), .T_RCD(TRCD), .T_RAS(TRAS),
    .T_WR(TWR), .T_RFC(TRFC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_autopre(req_autopre), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_ready(req_ready), .rd_capture(rd_capture), .cmd_cs_n(cs_n), .cmd_ras_n(ras_n),
    .cmd_cas_n(cas_n), .cmd_we_n(we_n), .cmd_ba(ba), .cmd_addr(addr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // command monitor: every non-NOP command with the cycle it appeared in
  always @(negedge clk) begin
    if (rst_n && {cs_n, ras_n, cas_n, we_n} != C_NOP && lg_n < LOGN) begin
      lg_cyc[lg_n]  = cyc;
      lg_cmd[lg_n]  = {cs_n, ras_n, cas_n, we_n};
      lg_ba[lg_n]   = ba;
      lg_addr[lg_n] = addr;
      if ({cs_n, ras_n, cas_n, we_n} == C_REF) begin
        ref_seen = ref_seen + 1;
        last_ref = cyc;
      end
      lg_n = lg_n + 1;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic do_req(input bit wr, input logic [1:0] b, input int row, input int col,
                        input bit ap);
    int n;
    @(negedge clk);
    req_write = wr; req_bank = b; req_row = ROW_W'(row); req_col = COL_W'(col);
    req_autopre = ap; req_valid = 1'b1;
    #1;
    n = 0;
    while (!req_ready && n < 200) begin
      @(negedge clk); #1; n++;
    end
    chk(req_ready, "R3 request never accepted", 0, 1);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
  endtask

  task automatic sync_ref();
    int r, n;
    r = ref_seen; n = 0;
    while (ref_seen == r && n < 2 * REFI) begin
      @(negedge clk); n++;
    end
    chk(ref_seen != r, "R8 refresh not seen", n, REFI);
    repeat (TRFC + 2) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n} == C_NOP, "R1 reset cmd", {cs_n, ras_n, cas_n, we_n}, C_NOP);
    chk(addr == 0 && ba == 0, "R1 reset addr/ba", int'(addr), 0);
    chk(!req_ready && !rd_capture, "R1 reset ready/rd", int'(req_ready), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n} == C_NOP, "R1 idle cmd", {cs_n, ras_n, cas_n, we_n}, C_NOP);
  endtask

  int act1_cyc;

  task automatic t_closed_read();
    int base, s;
    sync_ref();
    base = lg_n;
    do_req(1'b0, 2'd1, 'h155, 'h2A, 1'b0);
    chk(lg_n - base == 2, "R2 command count", lg_n - base, 2);
    chk(lg_cmd[base] == C_ACT, "R2 first is ACTIVE", lg_cmd[base], C_ACT);
    chk(lg_ba[base] == 1 && lg_addr[base] == 'h155, "R2 active row", int'(lg_addr[base]), 'h155);
    chk(lg_cmd[base+1] == C_RD && lg_ba[base+1] == 1, "R3 read cmd", lg_cmd[base+1], C_RD);
    chk(lg_addr[base+1] == 'h02A, "R3 column, ap=0", int'(lg_addr[base+1]), 'h02A);
    chk(lg_cyc[base+1] - lg_cyc[base] == TRCD, "R3 tRCD gap",
        lg_cyc[base+1] - lg_cyc[base], TRCD);
    act1_cyc = lg_cyc[base];
    s = lg_cyc[base+1];
    for (int k = 0; k < 8; k++) begin
      chk(rd_capture == ((cyc - s >= CL) && (cyc - s < CL + BEATS)), "R9 read strobe",
          int'(rd_capture), int'((cyc - s >= CL) && (cyc - s < CL + BEATS)));
      @(negedge clk); #1;
    end
  endtask

  task automatic t_hit();
    int base;
    base = lg_n;
    do_req(1'b0, 2'd1, 'h155, 'h10, 1'b0);
    do_req(1'b0, 2'd1, 'h155, 'h20, 1'b0);
    chk(lg_n - base == 2, "R4 only column commands", lg_n - base, 2);
    chk(lg_cmd[base] == C_RD && lg_cmd[base+1] == C_RD, "R4 no ACTIVE on hit",
        lg_cmd[base], C_RD);
    chk(lg_cyc[base+1] - lg_cyc[base] >= BEATS, "R4 column spacing",
        lg_cyc[base+1] - lg_cyc[base], BEATS);
  endtask

  task automatic t_miss();
    int base;
    base = lg_n;
    do_req(1'b0, 2'd1, 'h0AA, 'h3, 1'b0);
    chk(lg_n - base == 3, "R5 command count", lg_n - base, 3);
    chk(lg_cmd[base] == C_PRE && lg_ba[base] == 1, "R5 bank precharge", lg_cmd[base], C_PRE);
    chk(lg_addr[base][AP] == 1'b0, "R5 single-bank mode", int'(lg_addr[base][AP]), 0);
    chk(lg_cyc[base] - act1_cyc >= TRAS, "R5 tRAS", lg_cyc[base] - act1_cyc, TRAS);
    chk(lg_cmd[base+1] == C_ACT && lg_addr[base+1] == 'h0AA, "R5 new row",
        int'(lg_addr[base+1]), 'h0AA);
    chk(lg_cyc[base+1] - lg_cyc[base] == TRP, "R5 tRP gap", lg_cyc[base+1] - lg_cyc[base], TRP);
    chk(lg_cmd[base+2] == C_RD && lg_cyc[base+2] - lg_cyc[base+1] == TRCD, "R5 access tRCD",
        lg_cyc[base+2] - lg_cyc[base+1], TRCD);
  endtask

  task automatic t_autopre();
    int base, b2;
    sync_ref();
    base = lg_n;
    do_req(1'b1, 2'd2, 'h300, 'h05, 1'b1);
    chk(lg_cmd[base+1] == C_WR, "R6 write cmd", lg_cmd[base+1], C_WR);
    chk(lg_addr[base+1] == ADDR_W'((1 << AP) | 'h05), "R6 ap flag in addr",
        int'(lg_addr[base+1]), (1 << AP) | 'h05);
    b2 = lg_n;
    do_req(1'b0, 2'd2, 'h300, 'h06, 1'b0);
    chk(lg_cmd[b2] == C_ACT, "R6 reopen without PRE", lg_cmd[b2], C_ACT);
    chk(lg_cyc[b2] - lg_cyc[base+1] >= BEATS + TWR + TRP, "R6 reopen spacing",
        lg_cyc[b2] - lg_cyc[base+1], BEATS + TWR + TRP);
  endtask

  task automatic t_refresh_open();
    int base, r, n, ip;
    sync_ref();
    do_req(1'b0, 2'd3, 'h007, 'h01, 1'b0);
    base = lg_n;
    r = ref_seen; n = 0;
    while (ref_seen == r && n < 2 * REFI) begin
      @(negedge clk); n++;
    end
    #1;
    ip = lg_n - 2;
    chk(ip >= base && lg_cmd[ip] == C_PRE && lg_addr[ip][AP] == 1'b1, "R7 precharge-all",
        int'(lg_cmd[ip]), C_PRE);
    chk(lg_cmd[ip+1] == C_REF && lg_cyc[ip+1] - lg_cyc[ip] == TRP, "R7 tRP before refresh",
        lg_cyc[ip+1] - lg_cyc[ip], TRP);
    base = lg_n;
    do_req(1'b0, 2'd3, 'h007, 'h02, 1'b0);
    chk(lg_cmd[base] == C_ACT && lg_cyc[base] - last_ref >= TRFC, "R7 tRFC before ACTIVE",
        lg_cyc[base] - last_ref, TRFC);
  endtask

  task automatic t_refresh_load();
    int base, prev, refs, reads, stop;
    bit legal;
    sync_ref();
    base = lg_n; prev = last_ref; refs = 0; reads = 0; legal = 1'b1;
    stop = cyc + 3 * REFI;
    for (int i = 0; cyc < stop; i++) do_req(1'b0, 2'd0, 'h009, i & 'hFF, 1'b0);
    for (int j = base; j < lg_n; j++) begin
      if (!(lg_cmd[j] inside {C_ACT, C_RD, C_WR, C_PRE, C_REF})) legal = 1'b0;
      if (lg_cmd[j] == C_RD) reads++;
      if (lg_cmd[j] == C_REF) begin
        chk(lg_cyc[j] - prev <= REFI, "R8 refresh spacing", lg_cyc[j] - prev, REFI);
        prev = lg_cyc[j]; refs++;
      end
    end
    chk(legal, "R1 only legal codes", 0, 1);
    chk(refs >= 2, "R8 refresh under load", refs, 2);
    chk(reads > 50, "R4 requests served under load", reads, 51);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_closed_read();
    t_hit();
    t_miss();
    t_autopre();
    t_refresh_open();
    t_refresh_load();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule